// File: doc/BRIEF.md
# Boost Converter Fault Supervisor

This block gathers the digitised comparator flags around an LED boost converter. From them it decides two things. The first is when the power switch must be held off for the remainder of the current switching cycle. The second is when the converter as a whole must stop. It runs on a fast logic clock. A one-clock `cycle_start` strobe marks the beginning of each switching cycle, nominally 600 kHz. Open-LED detection counts these strobes. Over-current blanking is bounded by them.

An open string is recognised when the output-voltage sense is above the selected over-voltage threshold and some LED return pin reads low. Both must hold on a run of consecutive cycle strobes. That fault latches and stays latched until the sequencer enable drops, which is a full shutdown and restart. Undervoltage and over-temperature only gate the converter while they are present. An over-current trip blanks the switch only up to the next cycle start.

No data stream passes through the block, so it has no valid/ready interface. Every pin is a plain level or strobe.

Top module: `boost_fault_supervisor`

## Requirements
- R1: After reset `open_led_fault` is 0 and the over-current blank is clear. With `seq_en`=1 and no flags, `sw_off` is 0 and `conv_en` is 1.
- R2: `conv_en` is 1 exactly when `seq_en` is 1, `open_led_fault` is 0, `uvlo` is 0 and `otp` is 0.
- R3: The open-LED condition is `seq_en` high, `ovp_flags[ovp_sel]` high, and at least one bit of `led_low` high. When this condition is present on OPEN_CYCLES (default 8) consecutive clocks with `cycle_start` high, `open_led_fault` rises after the clock edge of the last of them, and not before.
- R4: A `cycle_start` clock on which the open-LED condition is false clears the count. A full new run of OPEN_CYCLES is then needed.
- R5: Once set, `open_led_fault` stays at 1 while `seq_en` stays high, even if the condition goes away. The first clock edge with `seq_en` low clears it.
- R6: Only the over-voltage flag at index `ovp_sel` counts. A high flag at any other index has no effect on detection.
- R7: `ocp_trip` high forces `sw_off` high in the same clock. The blank then holds after `ocp_trip` falls. It is cleared by the clock edge on which `cycle_start` is high.
- R8: `sw_off` is 1 whenever `conv_en` is 0.
- R9: `uvlo` and `otp` do not latch. `conv_en` returns to 1 as soon as they fall, provided there is no latched fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cycle_start | input | 1 | One-clock strobe at the start of each switching cycle |
| seq_en | input | 1 | Enable from the start-up sequencer; low means shutdown |
| ovp_flags | input | NUM_OVP_LEVELS | Over-voltage comparator outputs, one per threshold |
| ovp_sel | input | SEL_W | Index of the active over-voltage threshold |
| led_low | input | NUM_LED | LED return pin below open-string level, one per string |
| ocp_trip | input | 1 | Switch peak-current comparator |
| uvlo | input | 1 | Supply below lockout level |
| otp | input | 1 | Over-temperature flag |
| sw_off | output | 1 | Force the power switch off |
| open_led_fault | output | 1 | Latched open-LED fault |
| conv_en | output | 1 | Final converter enable |

## Verification
The assertions assume the following about the inputs:
- `cycle_start` is a single-clock pulse, separated from the next one by at least one low clock.
- `ovp_sel` stays within `NUM_OVP_LEVELS`.
- Comparator flags are already synchronised to `clk`.

The stimulus meets these assumptions. It changes inputs only on falling edges, raises `cycle_start` for exactly one clock with a low clock after it, and uses only selector values 0 and 1.

// File: rtl/fault_sup_pkg.sv
package fault_sup_pkg;
  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/bfs_open_led_det.sv
module bfs_open_led_det
  import fault_sup_pkg::*;
#(
  parameter int OPEN_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cycle_start,
  input  logic seq_en,
  input  logic cond,
  output logic fault
);
  localparam int CNT_W = cnt_width(OPEN_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OPEN_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else if (!seq_en) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else if (cycle_start) begin
      if (!cond) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        fault_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign fault = fault_q;

  // R5: latched fault survives while the sequencer stays enabled
  a_r5_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fault_q) && $past(seq_en)) |-> fault_q);

  // R4: a strobe without the condition clears the count
  a_r4_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cycle_start && !cond) |-> (cnt_q == '0));

  // R3: fault only rises on a qualifying strobe
  a_r3_rise_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> $past(cycle_start && cond && seq_en));

  // R3: count never passes the last step
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/bfs_ocp_blank.sv
module bfs_ocp_blank (
  input  logic clk,
  input  logic rst_n,
  input  logic cycle_start,
  input  logic ocp_trip,
  output logic blank
);
  logic blank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           blank_q <= 1'b0;
    else if (cycle_start) blank_q <= 1'b0;
    else if (ocp_trip)    blank_q <= 1'b1;
  end

  assign blank = blank_q | ocp_trip;

  // R7: a new cycle clears the stored blank
  a_r7_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cycle_start) |-> !blank_q);

  // R7: stored blank holds until a cycle start
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(blank_q && !cycle_start) |-> blank_q);
endmodule

// File: rtl/boost_fault_supervisor.sv
module boost_fault_supervisor
  import fault_sup_pkg::*;
#(
  parameter int NUM_LED        = 2,
  parameter int NUM_OVP_LEVELS = 2,
  parameter int OPEN_CYCLES    = 8,
  parameter int SEL_W          = (NUM_OVP_LEVELS > 1) ? $clog2(NUM_OVP_LEVELS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cycle_start,
  input  logic                      seq_en,
  input  logic [NUM_OVP_LEVELS-1:0] ovp_flags,
  input  logic [SEL_W-1:0]          ovp_sel,
  input  logic [NUM_LED-1:0]        led_low,
  input  logic                      ocp_trip,
  input  logic                      uvlo,
  input  logic                      otp,
  output logic                      sw_off,
  output logic                      open_led_fault,
  output logic                      conv_en
);
  logic ovp_active;
  logic open_cond;
  logic fault;
  logic blank;

  always_comb begin
    ovp_active = 1'b0;
    for (int i = 0; i < NUM_OVP_LEVELS; i++) begin
      if (SEL_W'(i) == ovp_sel) ovp_active = ovp_flags[i];
    end
  end

  assign open_cond = seq_en & ovp_active & (|led_low);

  bfs_open_led_det #(.OPEN_CYCLES(OPEN_CYCLES)) u_open (
    .clk        (clk),
    .rst_n      (rst_n),
    .cycle_start(cycle_start),
    .seq_en     (seq_en),
    .cond       (open_cond),
    .fault      (fault)
  );

  bfs_ocp_blank u_ocp (
    .clk        (clk),
    .rst_n      (rst_n),
    .cycle_start(cycle_start),
    .ocp_trip   (ocp_trip),
    .blank      (blank)
  );

  assign conv_en        = seq_en & ~fault & ~uvlo & ~otp;
  assign sw_off         = blank | ~conv_en;
  assign open_led_fault = fault;

  // R8: switch held off whenever the converter is disabled
  a_r8_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_en |-> sw_off);

  // R2: a latched fault always disables the converter
  a_r2_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    open_led_fault |-> !conv_en);

  // R7: a trip forces the switch off in the same clock
  a_r7_trip_off: assert property (@(posedge clk) disable iff (!rst_n)
    ocp_trip |-> sw_off);
endmodule

// File: tb/boost_fault_supervisor_tb.sv
module boost_fault_supervisor_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cycle_start = 1'b0;
  logic       seq_en = 1'b0;
  logic [1:0] ovp_flags = '0;
  logic [0:0] ovp_sel = '0;
  logic [1:0] led_low = '0;
  logic       ocp_trip = 1'b0;
  logic       uvlo = 1'b0;
  logic       otp = 1'b0;
  logic       sw_off, open_led_fault, conv_en;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boost_fault_supervisor u_dut (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .seq_en(seq_en),
    .ovp_flags(ovp_flags), .ovp_sel(ovp_sel), .led_low(led_low),
    .ocp_trip(ocp_trip), .uvlo(uvlo), .otp(otp),
    .sw_off(sw_off), .open_led_fault(open_led_fault), .conv_en(conv_en)
  );

  // {seq_en, uvlo, otp, expected conv_en}
  localparam logic [3:0] EN_TABLE [8] = '{
    4'b0000, 4'b0010, 4'b0100, 4'b0110,
    4'b1001, 4'b1010, 4'b1100, 4'b1110
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) cycle_start = 1'b1;
    @(negedge clk) cycle_start = 1'b0;
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) strobe();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 fault after reset", open_led_fault, 1'b0);
    check("R8 sw_off while disabled", sw_off, 1'b1);
    seq_en = 1'b1;
    #1;
    check("R1 sw_off enabled idle", sw_off, 1'b0);
    check("R1 conv_en enabled idle", conv_en, 1'b1);

    // R2 R9: enable table walk
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      {seq_en, uvlo, otp} = EN_TABLE[k][3:1];
      #1;
      check("R2 conv_en table", conv_en, EN_TABLE[k][0]);
      check("R8 sw_off table", sw_off, ~EN_TABLE[k][0]);
    end
    @(negedge clk);
    seq_en = 1'b1; uvlo = 1'b0; otp = 1'b0;
    #1;
    check("R9 uvlo/otp not latched", conv_en, 1'b1);

    // R3: eight qualifying strobes
    ovp_sel = 1'b0; ovp_flags = 2'b01; led_low = 2'b01;
    strobes(7);
    check("R3 no fault after 7", open_led_fault, 1'b0);
    strobe();
    check("R3 fault after 8", open_led_fault, 1'b1);
    check("R2 conv_en off on fault", conv_en, 1'b0);

    // R5: sticky, cleared by seq_en low
    ovp_flags = 2'b00; led_low = 2'b00;
    strobes(3);
    check("R5 fault sticky", open_led_fault, 1'b1);
    @(negedge clk) seq_en = 1'b0;
    @(negedge clk) seq_en = 1'b1;
    check("R5 fault cleared by shutdown", open_led_fault, 1'b0);
    #1;
    check("R5 conv_en back", conv_en, 1'b1);

    // R4: interrupted run restarts count
    ovp_flags = 2'b01; led_low = 2'b10;
    strobes(5);
    led_low = 2'b00;
    strobe();
    led_low = 2'b10;
    strobes(7);
    check("R4 no fault after break+7", open_led_fault, 1'b0);
    strobe();
    check("R4 fault after fresh 8", open_led_fault, 1'b1);
    @(negedge clk) seq_en = 1'b0;
    @(negedge clk) seq_en = 1'b1;

    // R6: non-selected flag ignored
    ovp_sel = 1'b1; ovp_flags = 2'b01; led_low = 2'b01;
    strobes(10);
    check("R6 other level ignored", open_led_fault, 1'b0);
    ovp_flags = 2'b10;
    strobes(7);
    check("R6 selected level 7", open_led_fault, 1'b0);
    strobe();
    check("R6 selected level 8", open_led_fault, 1'b1);
    @(negedge clk) seq_en = 1'b0;
    @(negedge clk) seq_en = 1'b1;
    ovp_flags = 2'b00; led_low = 2'b00;

    // R7: over-current blanking
    @(negedge clk) ocp_trip = 1'b1;
    #1;
    check("R7 trip same clock", sw_off, 1'b1);
    @(negedge clk) ocp_trip = 1'b0;
    #1;
    check("R7 blank held", sw_off, 1'b1);
    repeat (3) @(negedge clk);
    check("R7 blank still held", sw_off, 1'b1);
    strobe();
    check("R7 cleared by cycle start", sw_off, 1'b0);
    check("R7 conv_en unaffected", conv_en, 1'b1);

    // R8: shutdown forces switch off
    @(negedge clk) seq_en = 1'b0;
    #1;
    check("R8 sw_off on shutdown", sw_off, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule